// File: doc/BRIEF.md
# Recursive-Doubling Scan Engine

The block takes a vector of N words and returns every running combination of it under one associative operator chosen per job. Lane i of the result holds the ordered combination of lanes 0 through i. In the reversed direction it holds lanes i through N-1. The work is done in lg N registered rounds. In the round with index j, each lane combines with the lane at distance 2^j, and all lanes update together from the values the previous round left in the registers.

A one-cycle start request while idle captures the vector, the operator code and the direction. The engine then runs its rounds without further input and raises a one-cycle done flag when the result is on the output. The result stays on the output until the next job is accepted. Start requests that arrive while a job is running are dropped. The combining cell always places the lower-index value on the left, so the schedule stays correct for operators that are associative but not commutative.

Top module: `pscan_top`

## Requirements
- R1: After reset, busy and done are 0 and every output lane is 0.
- R2: A start seen at a rising edge while busy is 0 is accepted. busy reads 1 after that edge, done reads 1 only in the cycle after the edge that comes lg N edges after the accepting edge, and busy reads 0 in that same cycle.
- R3: With suffix = 0, output lane i equals in0 op in1 op ... op in_i, with lower-index operands on the left. Lane 0 equals input lane 0.
- R4: With suffix = 1, output lane i equals in_i op ... op in_(N-1), with lower-index operands on the left. Lane N-1 equals input lane N-1.
- R5: Operator codes on op_sel: 0 = add modulo 2^W, 1 = unsigned maximum, 2 = unsigned minimum, 3 = bitwise AND, 4 = bitwise OR, 5 = bitwise XOR. Codes 6 and 7 behave as add.
- R6: A start while busy is 1 has no effect. The finished result reflects the vector, operator and direction captured at acceptance, even if din, op_sel and suffix change during the job.
- R7: done is high for exactly one cycle, and dout holds its value from that cycle until the next job is accepted.
- R8: Input and output lane i occupy bits [i*W +: W] of din and dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Job request, sampled only while idle |
| op_sel | input | 3 | Operator code (R5) |
| suffix | input | 1 | 0 = left-to-right scan, 1 = right-to-left scan |
| din | input | N*W | Input vector, lane i at bits [i*W +: W] |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle flag: dout holds a finished result |
| dout | output | N*W | Result vector, lane i at bits [i*W +: W] |

## Verification
The assertions assume no particular timing of start. They rely only on reset flushing the control state, and they treat din, op_sel and suffix as meaningful only in the cycle a job is accepted. The stimulus holds start high through whole jobs and drives inverted data, a different operator and the opposite direction while busy, so the assertions that guard captured state see the input pins move. Operator codes, directions and lane values are drawn from a seeded random source, together with directed all-ones, all-zeros and extreme-value vectors that force the add wrap and the max and min edge cases.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MAX = 3'd1,
    OP_MIN = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5
  } op_e;
endpackage

// File: rtl/pscan_cell.sv
module pscan_cell #(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] res
);
  import pscan_pkg::*;

  // lo is always the lower-index operand (left side of the operator)
  always_comb begin
    case (op)
      OP_MAX:  res = (lo >= hi) ? lo : hi;
      OP_MIN:  res = (lo <= hi) ? lo : hi;
      OP_AND:  res = lo & hi;
      OP_OR:   res = lo | hi;
      OP_XOR:  res = lo ^ hi;
      default: res = lo + hi;
    endcase
  end
endmodule

// File: rtl/pscan_stage.sv
module pscan_stage #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int LG = 3,
  parameter int RW = 2
) (
  input  logic [N-1:0][W-1:0] cur,
  input  logic [RW-1:0]       rnd,
  input  logic                sfx,
  input  logic [2:0]          op,
  output logic [N-1:0][W-1:0] nxt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [W-1:0] lo, hi, res;
    logic         upd;

    always_comb begin
      lo  = cur[i];
      hi  = cur[i];
      upd = 1'b0;
      for (int k = 0; k < LG; k++) begin
        if (rnd == RW'(k)) begin
          if (!sfx) begin
            if (i >= (1 << k)) begin
              lo  = cur[IW'(i - (1 << k))];
              upd = 1'b1;
            end
          end else if (i + (1 << k) < N) begin
            hi  = cur[IW'(i + (1 << k))];
            upd = 1'b1;
          end
        end
      end
    end

    pscan_cell #(.W(W)) u_cell (
      .op  (op),
      .lo  (lo),
      .hi  (hi),
      .res (res)
    );

    assign nxt[i] = upd ? res : cur[i];
  end
endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl #(
  parameter int LG = 3,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic [RW-1:0] rnd,
  output logic          done
);
  localparam logic [RW-1:0] LAST = RW'(LG - 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [RW-1:0] rnd_q, rnd_n;

  assign accept = start & ~busy_q;

  always_comb begin
    busy_n = busy_q;
    rnd_n  = rnd_q;
    done_n = 1'b0;
    if (accept) begin
      busy_n = 1'b1;
      rnd_n  = '0;
    end else if (busy_q) begin
      if (rnd_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        rnd_n  = '0;
      end else begin
        rnd_n = rnd_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      rnd_q  <= rnd_n;
    end
  end

  assign busy = busy_q;
  assign rnd  = rnd_q;
  assign done = done_q;

  // R2: done only follows the last round of a running job
  a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && $past(rnd_q) == LAST));

  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a start during a job does not restart the round count
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && rnd_q != LAST) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));
endmodule

// File: rtl/pscan_top.sv
module pscan_top #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op_sel,
  input  logic           suffix,
  input  logic [N*W-1:0] din,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] dout
);
  localparam int LG = (N > 1) ? $clog2(N) : 1;
  localparam int RW = (LG > 1) ? $clog2(LG) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic                accept;
  logic [RW-1:0]       rnd;
  logic [N-1:0][W-1:0] arr_q, arr_n, stage_nxt;
  logic [2:0]          op_q;
  logic                sfx_q;
  logic                arr_en;

  pscan_ctrl #(.LG(LG), .RW(RW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_ni),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .rnd    (rnd),
    .done   (done)
  );

  pscan_stage #(.N(N), .W(W), .LG(LG), .RW(RW)) u_stage (
    .cur (arr_q),
    .rnd (rnd),
    .sfx (sfx_q),
    .op  (op_q),
    .nxt (stage_nxt)
  );

  assign arr_en = accept | busy;

  always_comb begin
    if (accept) arr_n = din;
    else        arr_n = stage_nxt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q <= '0;
    end else if (arr_en) begin
      arr_q <= arr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      sfx_q <= 1'b0;
    end else if (accept) begin
      op_q  <= op_sel;
      sfx_q <= suffix;
    end
  end

  assign dout = arr_q;

  // R6: captured job settings stay fixed while a job runs
  a_r6_settings_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && start) |=> (op_q == $past(op_q) && sfx_q == $past(sfx_q)));

  // R3: lane 0 is never rewritten during a left-to-right job
  a_r3_lane0_fixed: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !sfx_q) |=> arr_q[0] == $past(arr_q[0]));

  // R4: the top lane is never rewritten during a right-to-left job
  a_r4_top_fixed: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && sfx_q) |=> arr_q[N-1] == $past(arr_q[N-1]));

  // R7: result is held while idle with no new request
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && !start) |=> $stable(dout));
endmodule

// File: tb/pscan_top_test.sv
`timescale 1ns/1ps
module pscan_top_test;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int LG = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2:0]     op_sel = '0;
  logic           suffix = 1'b0;
  logic [N*W-1:0] din = '0;
  logic           busy, done;
  logic [N*W-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pscan_top #(.N(N), .W(W)) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .op_sel (op_sel),
    .suffix (suffix), .din (din), .busy (busy), .done (done), .dout (dout)
  );

  function automatic logic [W-1:0] f_op(logic [2:0] o, logic [W-1:0] a, logic [W-1:0] b);
    case (o)
      3'd1:    return (a >= b) ? a : b;
      3'd2:    return (a <= b) ? a : b;
      3'd3:    return a & b;
      3'd4:    return a | b;
      3'd5:    return a ^ b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [N*W-1:0] f_scan(logic [2:0] o, logic s, logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    logic [W-1:0]   acc;
    r = '0;
    if (!s) begin
      acc = v[0 +: W];
      r[0 +: W] = acc;
      for (int i = 1; i < N; i++) begin
        acc = f_op(o, acc, v[i*W +: W]);
        r[i*W +: W] = acc;
      end
    end else begin
      acc = v[(N-1)*W +: W];
      r[(N-1)*W +: W] = acc;
      for (int i = N-2; i >= 0; i--) begin
        acc = f_op(o, v[i*W +: W], acc);
        r[i*W +: W] = acc;
      end
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(logic [2:0] o, logic s, logic [N*W-1:0] v, bit disturb, string tag);
    logic [N*W-1:0] exp;
    exp = f_scan(o, s, v);
    @(negedge clk);
    din = v; op_sel = o; suffix = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", {{(N*W-1){1'b0}}, busy}, 1);
    if (disturb) begin
      din = ~v; op_sel = o ^ 3'd1; suffix = ~s; start = 1'b1;
    end
    for (int c = 1; c < LG; c++) begin
      @(negedge clk);
      chk(done == 1'b0, "R2 done too early", {{(N*W-1){1'b0}}, done}, 0);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R2 done timing", {{(N*W-2){1'b0}}, done, busy}, 2);
    chk(dout == exp, tag, dout, exp);
    if (disturb) chk(dout == exp, "R6 start while busy", dout, exp);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", {{(N*W-1){1'b0}}, done}, 0);
    chk(dout == exp, "R7 result held", dout, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] v;
    void'($urandom(32'h5ca1_ab1e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {{(N*W-2){1'b0}}, busy, done}, 0);
    chk(dout == '0, "R1 lanes zero", dout, '0);

    // R5 add wraps modulo 2^W; R3 prefix order
    run(3'd0, 1'b0, {N*W{1'b1}}, 1'b0, "R5 R3 add wrap prefix");
    // R8 lane placement with a single nonzero lane
    v = '0; v[2*W +: W] = 16'h0001;
    run(3'd0, 1'b0, v, 1'b0, "R8 lane position prefix");
    run(3'd0, 1'b1, v, 1'b0, "R8 lane position suffix");
    // R5 max/min extremes, R4 suffix
    v = '0; v[5*W +: W] = 16'hFFFF; v[1*W +: W] = 16'h8000;
    run(3'd1, 1'b0, v, 1'b0, "R5 max prefix");
    run(3'd2, 1'b1, ~v, 1'b0, "R5 R4 min suffix");
    run(3'd3, 1'b0, {N*W{1'b1}}, 1'b0, "R5 and all ones");
    run(3'd4, 1'b1, '0, 1'b0, "R5 R4 or all zeros");
    run(3'd6, 1'b0, {N{16'h4001}}, 1'b0, "R5 code 6 as add");
    run(3'd7, 1'b1, {N{16'hC003}}, 1'b0, "R5 code 7 as add");
    // R6 inputs churn during the job
    v = {$urandom, $urandom, $urandom, $urandom};
    run(3'd5, 1'b0, v, 1'b1, "R5 R3 xor prefix");
    run(3'd0, 1'b1, v, 1'b1, "R5 R4 add suffix");

    for (int t = 0; t < 60; t++) begin
      logic [2:0] o;
      logic       s;
      o = 3'($urandom_range(0, 7));
      s = 1'($urandom_range(0, 1));
      v = {$urandom, $urandom, $urandom, $urandom};
      run(o, s, v, 1'($urandom_range(0, 1)), s ? "R4 random suffix" : "R3 random prefix");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule